// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This block moderates the interrupt rate of one DMA channel. A completion counter is loaded from a programmable threshold. It counts down once for each completion strobe. When the count runs out, the block raises a completion flag and loads the counter again.

A second mechanism is a one-shot delay timer. Each completion restarts it with a programmable delay whenever that delay is nonzero. When the timer runs out, the block raises a delay flag and also reloads the completion counter. A small trickle of completions therefore still produces an interrupt, even if it never reaches the threshold.

The timer advances only on a prescaled tick: every PRESC_DIV-th pulse of `tick_i` while the timer runs. Both flags are cleared by write-one-to-clear requests. Each flag is gated by its own enable bit onto one interrupt line. The live counter and timer values are brought out for status readback.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, flags_o is 0, count_o is 1, timer_o is 0 and irq_o is 0.
- R2: A completion strobe with count_o above 1 decrements count_o by one. A completion with count_o equal to 1 sets flags_o bit 0 (the completion flag) and loads count_o with the effective threshold, one cycle later.
- R3: A threshold of 0 is treated as 1, both for reloads and for the completion flag.
- R4: A control-write strobe loads count_o with the effective threshold on the next cycle. This takes precedence over any decrement in the same cycle.
- R5: A completion with delay_i nonzero loads timer_o with delay_i on the next cycle and restarts the prescaler. This happens even if the timer is already running.
- R6: While timer_o is nonzero, it decrements by one on every PRESC_DIV-th tick_i pulse counted since its last restart. Without a tick_i pulse and without a completion, timer_o holds its value.
- R7: When the timer steps from 1 to 0, flags_o bit 1 (the delay flag) is set and count_o is loaded with the effective threshold.
- R8: A completion with delay_i equal to 0 does not load or restart the timer.
- R9: A 1 in clr_i clears the matching flag bit. If that flag is being set in the same cycle, it ends up set.
- R10: irq_o is high exactly when some bit is set both in flags_o and in irq_en_i (bit 0 enables the completion flag, bit 1 the delay flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_i | input | 1 | One-cycle completion strobe |
| tick_i | input | 1 | Timer tick pulse before prescaling |
| ctrl_wr_i | input | 1 | Control-write strobe, reloads the counter |
| thresh_i | input | CNT_W | Completion threshold |
| delay_i | input | DLY_W | Delay timer load value, 0 disables |
| irq_en_i | input | 2 | Per-flag interrupt enables |
| clr_i | input | 2 | Write-one-to-clear requests for the flags |
| flags_o | output | 2 | Pending flags: bit 0 completion, bit 1 delay |
| count_o | output | CNT_W | Live completion counter |
| timer_o | output | DLY_W | Live delay timer |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions check the following on every cycle:
- the counter never reads zero;
- a control write or a restart lands in the counter or timer one cycle later;
- the timer holds when it sees no tick and no completion;
- a completion at count 1 always leaves the completion flag set, whatever clear arrives with it;
- a timer expiry always shows the delay flag.

Only the bench scenarios can show the rest. These are the exact decrement sequence across thresholds, the zero-threshold case, the prescaler ratio between ticks and timer steps, a zero delay leaving the timer alone, and the enable gating of the interrupt line. The bench checks these against its reference model on every clock and with directed values.

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int CNT_W     = 8,
  parameter int DLY_W     = 8,
  parameter int PRESC_DIV = 2,
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpl_i,
  input  logic             tick_i,
  input  logic             ctrl_wr_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [1:0]       irq_en_i,
  input  logic [1:0]       clr_i,
  output logic [1:0]       flags_o,
  output logic [CNT_W-1:0] count_o,
  output logic [DLY_W-1:0] timer_o,
  output logic             irq_o
);

  logic [PW-1:0]    pre;
  logic [CNT_W-1:0] eff_th;
  logic             restart, run_tick, step, expire, hit;

  assign eff_th   = (thresh_i == '0) ? CNT_W'(1) : thresh_i;
  assign restart  = cmpl_i && (delay_i != '0);
  assign run_tick = (timer_o != '0) && tick_i;
  assign step     = run_tick && (pre == PW'(PRESC_DIV - 1));
  assign expire   = step && (timer_o == DLY_W'(1)) && !restart;
  assign hit      = cmpl_i && (count_o <= CNT_W'(1));
  assign irq_o    = |(flags_o & irq_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o <= '0;
      count_o <= CNT_W'(1);
      timer_o <= '0;
      pre     <= '0;
    end else begin
      flags_o <= (flags_o & ~clr_i) | {expire, hit};
      if (ctrl_wr_i || expire || hit)
        count_o <= eff_th;
      else if (cmpl_i)
        count_o <= count_o - CNT_W'(1);
      if (restart) begin
        timer_o <= delay_i;
        pre     <= '0;
      end else if (run_tick) begin
        pre <= step ? '0 : pre + PW'(1);
        if (step)
          timer_o <= timer_o - DLY_W'(1);
      end
    end
  end

endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
  parameter int CNT_W = 8,
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmpl_i,
  input logic             tick_i,
  input logic             ctrl_wr_i,
  input logic [CNT_W-1:0] thresh_i,
  input logic [DLY_W-1:0] delay_i,
  input logic [1:0]       flags_o,
  input logic [CNT_W-1:0] count_o,
  input logic [DLY_W-1:0] timer_o
);

  a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    count_o != '0);

  a_r4_ctrl_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_i |=> count_o == (($past(thresh_i) == '0) ? CNT_W'(1) : $past(thresh_i)));

  a_r5_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_i && delay_i != '0) |=> timer_o == $past(delay_i));

  a_r6_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cmpl_i) |=> $stable(timer_o));

  a_r8_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_i && delay_i == '0 && !tick_i) |=> $stable(timer_o));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_i && count_o == CNT_W'(1)) |=> flags_o[0]);

  a_r7_expiry_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_o == '0 && $past(timer_o) == DLY_W'(1)) |-> flags_o[1]);

endmodule

bind irq_coalesce irq_coalesce_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/tb_irq_coalesce.sv
`timescale 1ns/1ps
module tb_irq_coalesce;
  localparam int CW = 8, DW = 8, DIV = 2;

  logic clk = 0, rst_n = 0;
  logic cmpl_i = 0, tick_i = 0, ctrl_wr_i = 0;
  logic [CW-1:0] thresh_i = 0;
  logic [DW-1:0] delay_i = 0;
  logic [1:0] irq_en_i = 0, clr_i = 0;
  logic [1:0] flags_o;
  logic [CW-1:0] count_o;
  logic [DW-1:0] timer_o;
  logic irq_o;

  irq_coalesce #(.CNT_W(CW), .DLY_W(DW), .PRESC_DIV(DIV)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  int m_cnt, m_tmr, m_pre, m_flg;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Reference model, updated at each rising edge from the sampled inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 1; m_tmr = 0; m_pre = 0; m_flg = 0;
    end else begin
      int eff, dly, ncnt, ntmr, npre, setv;
      bit stp, exp_, h;
      eff  = (thresh_i == 0) ? 1 : int'(thresh_i);
      dly  = int'(delay_i);
      stp  = (m_tmr != 0) && tick_i && (m_pre == DIV - 1);
      h    = cmpl_i && (m_cnt == 1);
      exp_ = stp && (m_tmr == 1) && !(cmpl_i && dly != 0);
      ncnt = m_cnt;
      if (cmpl_i) ncnt = h ? eff : m_cnt - 1;
      if (exp_ || ctrl_wr_i) ncnt = eff;
      ntmr = m_tmr; npre = m_pre;
      if (cmpl_i && dly != 0) begin ntmr = dly; npre = 0; end
      else if (m_tmr != 0 && tick_i) begin
        npre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
        if (stp) ntmr = m_tmr - 1;
      end
      setv = (exp_ ? 2 : 0) | (h ? 1 : 0);
      m_flg = (m_flg & ~int'(clr_i)) | setv;
      m_cnt = ncnt; m_tmr = ntmr; m_pre = npre;
    end
  end

  // Per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R2 count", int'(count_o), m_cnt);
      chk("R6 timer", int'(timer_o), m_tmr);
      chk("R9 flags", int'(flags_o), m_flg);
      chk("R10 irq", int'(irq_o), ((m_flg & int'(irq_en_i)) != 0) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      summary();
    end
  end

  task automatic cyc(bit c = 0, bit t = 0, bit w = 0, logic [1:0] cl = 0);
    cmpl_i = c; tick_i = t; ctrl_wr_i = w; clr_i = cl;
    @(posedge clk); @(negedge clk);
    cmpl_i = 0; tick_i = 0; ctrl_wr_i = 0; clr_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", int'(flags_o), 0);
    chk("R1 count", int'(count_o), 1);
    chk("R1 timer", int'(timer_o), 0);
    chk("R1 irq", int'(irq_o), 0);

    // R4 reload on control write, R2 countdown
    thresh_i = 3; delay_i = 0;
    cyc(0, 0, 1);
    chk("R4 reload", int'(count_o), 3);
    cyc(1); chk("R2 dec", int'(count_o), 2);
    cyc(1); chk("R2 dec", int'(count_o), 1);
    chk("R2 no flag yet", int'(flags_o), 0);
    cyc(1);
    chk("R2 flag", int'(flags_o), 1);
    chk("R2 reload", int'(count_o), 3);
    cyc(0, 0, 0, 2'b01);
    chk("R9 clear", int'(flags_o), 0);

    // R3 zero threshold
    thresh_i = 0;
    cyc(0, 0, 1);
    chk("R3 reload", int'(count_o), 1);
    cyc(1, 0, 0, 2'b01);
    chk("R9 set wins", int'(flags_o), 1);
    chk("R3 reload one", int'(count_o), 1);
    cyc(0, 0, 0, 2'b01);
    chk("R9 clear", int'(flags_o), 0);

    // R5 restart, R6 prescaled stepping
    thresh_i = 4; cyc(0, 0, 1);
    delay_i = 3;
    cyc(1);
    chk("R5 load", int'(timer_o), 3);
    cyc(0, 1); chk("R6 first tick", int'(timer_o), 3);
    cyc(0, 1); chk("R6 step", int'(timer_o), 2);
    repeat (3) cyc();
    chk("R6 hold", int'(timer_o), 2);
    cyc(0, 1);
    cyc(1);
    chk("R5 restart", int'(timer_o), 3);
    chk("R2 dec", int'(count_o), 2);
    // R7 expiry
    repeat (6) cyc(0, 1);
    chk("R7 timer", int'(timer_o), 0);
    chk("R7 flag", int'(flags_o), 2);
    chk("R7 reload", int'(count_o), 4);
    // R10 gating
    irq_en_i = 2'b01; @(negedge clk);
    chk("R10 masked", int'(irq_o), 0);
    irq_en_i = 2'b10; @(negedge clk);
    chk("R10 enabled", int'(irq_o), 1);
    cyc(0, 0, 0, 2'b10);
    chk("R10 cleared", int'(irq_o), 0);
    // R8 zero delay leaves timer idle
    delay_i = 0;
    cyc(1);
    chk("R8 idle", int'(timer_o), 0);

    // Random traffic compared against the model each clock
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15) == 0) thresh_i = CW'($urandom_range(5));
      if ($urandom_range(15) == 0) delay_i = DW'($urandom_range(6));
      if ($urandom_range(31) == 0) irq_en_i = 2'($urandom_range(3));
      cyc($urandom_range(3) == 0, $urandom_range(1) == 0,
          $urandom_range(15) == 0,
          ($urandom_range(7) == 0) ? 2'($urandom_range(3)) : 2'b00);
    end
    done = 1;
    summary();
  end
endmodule